// File: doc/BRIEF.md
# Command-List Launch Controller

This block sits between a host processor and a small command-list engine. The host fills a word-addressed command memory through a simple register bus, then writes a start address to start the engine. The engine fetches one 16-bit command per cycle. A command word holds a 5-bit opcode in bits 15:11 and an 11-bit argument in bits 10:0. The controller decodes just enough of each opcode to recognise the stop codes. Every other command is treated as a one-cycle no-op that moves the fetch pointer on by one word.

A run ends in one of three ways: a stop opcode, a write to the stop register, or a host access to guarded space while the engine is busy. Every ending sets a sticky done flag. When the interrupt enable is also set, the flag pulls the active-low interrupt output low. While the engine runs, the host may still reach the state, stop, done, enable and two spare storage registers without disturbing the run.

Top module: `clc_launch_top`

## Requirements
- R1: The opcode is bits 15:11 of a command word. Every opcode other than 5'h00, 5'h01, 5'h1E and 5'h1F moves the fetch pointer forward one word per cycle while the engine runs. Opcode 5'h1D is one such no-op.
- R2: The register space is selected by host address bit 6, with the register index in bits 2:0. The start register is index 0. A write to it while idle loads the pointer from write data bits 5:0 and sets the run bit (index 1, bit 0) at that edge. The first command is fetched in the following cycle.
- R3: Fetching opcode 5'h00 (halt) or 5'h01 (breakpoint) clears the run bit at that edge. The pointer keeps the address of the stopping command. Reading index 0 while idle returns the pointer.
- R4: Fetching opcode 5'h1E or 5'h1F (reserved) stops the run in the same way as R3.
- R5: Any write to the stop register (index 2) while running clears the run bit at that edge, and the pointer holds. The same write while idle has no effect and leaves the done flag clear.
- R6: While running, any host access to command memory (address bit 6 = 0), to index 0 or to index 7 stops the run at that edge with the pointer held. A memory write made this way is discarded.
- R7: While running, accesses to indexes 1 to 6 leave the run going.
- R8: Every stop sets the done flag (index 4, bit 0). Writing 1 to that bit clears the flag. Writing 0 leaves it set. A stop in the same cycle as a clear wins.
- R9: `irq_n` is low exactly when both the done flag and the enable bit (index 5, bit 0) are 1.
- R10: While idle, the host can write command memory and read it back. The spare registers hold their values: index 3 holds bit 0 and index 6 holds bits 7:0.
- R11: After reset, the run bit, done flag, enable bit and spare registers are 0, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access strobe for this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 7 | Bit 6 selects registers; memory word or register index below |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data for the current access |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The engine is started on lists of different shapes: plain no-ops that end in a halt, a breakpoint as the very first word, and no-op runs ending in each reserved code. Polling the run bit cycle by cycle shows the exact length of a run. The pointer read afterwards separates a stop taken on the right word from one taken a word early or late. Host-driven stops are tried three ways: a stop write, a guarded memory write, and a pointer read. These show that each path ends the run and that the discarded write never lands. A burst of accesses to the allowed registers, followed by a run-bit read, tells the guarded set apart from the allowed set.

// File: rtl/clc_pkg.sv
package clc_pkg;

   typedef enum logic [2:0] {
      REG_START = 3'd0,
      REG_STATE = 3'd1,
      REG_STOP  = 3'd2,
      REG_XDIS  = 3'd3,
      REG_DONE  = 3'd4,
      REG_IEN   = 3'd5,
      REG_NMIS  = 3'd6,
      REG_SPARE = 3'd7
   } reg_idx_e;

   // registers reachable while the engine runs, one bit per index
   localparam logic [7:0] FREE_WHILE_RUN = 8'b0111_1110;

   localparam int NMIS_W = 8;

endpackage

// File: rtl/clc_cmd_ram.sv
module clc_cmd_ram #(
   parameter int DW = 16,
   parameter int AW = 6,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] fetch_addr,
   output logic [DW-1:0] fetch_data,
   input  logic [AW-1:0] host_addr,
   output logic [DW-1:0] host_data
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign fetch_data = mem[fetch_addr];
   assign host_data  = mem[host_addr];

endmodule

// File: rtl/clc_host_dec.sv
module clc_host_dec
   import clc_pkg::*;
(
   input  logic     sel,
   input  logic     we,
   input  logic     reg_space,
   input  reg_idx_e idx,
   output logic     ram_hit,
   output logic     reg_hit,
   output logic     guarded,
   output logic     start_wr,
   output logic     kill_wr
);

   logic [7:0] free_vec;

   for (genvar i = 0; i < 8; i++) begin : g_free
      assign free_vec[i] = FREE_WHILE_RUN[i];
   end

   assign ram_hit  = sel && !reg_space;
   assign reg_hit  = sel && reg_space;
   assign guarded  = ram_hit || (reg_hit && !free_vec[idx]);
   assign start_wr = reg_hit && we && (idx == REG_START);
   assign kill_wr  = reg_hit && we && (idx == REG_STOP);

endmodule

// File: rtl/clc_seq.sv
module clc_seq #(
   parameter int AW     = 6,
   parameter int OP_W   = 5,
   parameter int RSV_LO = 30,
   localparam int OP_N  = 1 << OP_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_wr,
   input  logic [AW-1:0]   start_addr,
   input  logic            host_stop,
   input  logic [OP_W-1:0] opcode,
   output logic            run,
   output logic [AW-1:0]   ptr,
   output logic            stop_evt
);

   logic is_rsv;
   logic op_stop;

   if (RSV_LO >= OP_N) begin : g_no_rsv
      assign is_rsv = 1'b0;
   end else begin : g_rsv
      assign is_rsv = (opcode >= OP_W'(RSV_LO));
   end

   assign op_stop  = (opcode == OP_W'(0)) || (opcode == OP_W'(1)) || is_rsv;
   assign stop_evt = run && (op_stop || host_stop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         ptr <= '0;
      end else if (!run) begin
         if (start_wr) begin
            run <= 1'b1;
            ptr <= start_addr;
         end
      end else if (stop_evt) begin
         run <= 1'b0;
      end else begin
         ptr <= ptr + 1'b1;
      end
   end

endmodule

// File: rtl/clc_launch_top.sv
module clc_launch_top
   import clc_pkg::*;
#(
   parameter int RAM_AW = 6,
   parameter int CMD_W  = 16,
   parameter int OP_W   = 5,
   parameter int RSV_LO = 30,
   localparam int HA_W  = RAM_AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_sel,
   input  logic             host_we,
   input  logic [HA_W-1:0]  host_addr,
   input  logic [CMD_W-1:0] host_wdata,
   output logic [CMD_W-1:0] host_rdata,
   output logic             irq_n
);

   if (RAM_AW < 3 || RAM_AW > 11) begin : g_bad_aw
      $error("RAM_AW must lie in 3..11");
   end
   if (CMD_W < 8 || OP_W < 2 || OP_W >= CMD_W) begin : g_bad_w
      $error("command width too narrow for opcode and spare register");
   end

   reg_idx_e            idx;
   logic                ram_hit, reg_hit, guarded, start_wr, kill_wr;
   logic                run, stop_evt;
   logic [RAM_AW-1:0]   ptr;
   logic [CMD_W-1:0]    fetch_word, ram_rd;
   logic [OP_W-1:0]     fetch_op;
   logic                done_flag, ien, xdis;
   logic [NMIS_W-1:0]   nmis;
   logic                reg_wr;

   assign idx      = reg_idx_e'(host_addr[2:0]);
   assign fetch_op = fetch_word[CMD_W-1 -: OP_W];
   assign reg_wr   = reg_hit && host_we;

   clc_host_dec u_dec (
      .sel       (host_sel),
      .we        (host_we),
      .reg_space (host_addr[HA_W-1]),
      .idx       (idx),
      .ram_hit   (ram_hit),
      .reg_hit   (reg_hit),
      .guarded   (guarded),
      .start_wr  (start_wr),
      .kill_wr   (kill_wr)
   );

   clc_cmd_ram #(.DW(CMD_W), .AW(RAM_AW)) u_ram (
      .clk        (clk),
      .wr_en      (ram_hit && host_we && !run),
      .wr_addr    (host_addr[RAM_AW-1:0]),
      .wr_data    (host_wdata),
      .fetch_addr (ptr),
      .fetch_data (fetch_word),
      .host_addr  (host_addr[RAM_AW-1:0]),
      .host_data  (ram_rd)
   );

   clc_seq #(.AW(RAM_AW), .OP_W(OP_W), .RSV_LO(RSV_LO)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_wr   (start_wr),
      .start_addr (host_wdata[RAM_AW-1:0]),
      .host_stop  (kill_wr || guarded),
      .opcode     (fetch_op),
      .run        (run),
      .ptr        (ptr),
      .stop_evt   (stop_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_flag <= 1'b0;
         ien       <= 1'b0;
         xdis      <= 1'b0;
         nmis      <= '0;
      end else begin
         if (stop_evt)
            done_flag <= 1'b1;
         else if (reg_wr && idx == REG_DONE && host_wdata[0])
            done_flag <= 1'b0;
         if (reg_wr && idx == REG_IEN)  ien  <= host_wdata[0];
         if (reg_wr && idx == REG_XDIS) xdis <= host_wdata[0];
         if (reg_wr && idx == REG_NMIS) nmis <= host_wdata[NMIS_W-1:0];
      end
   end

   always_comb begin
      host_rdata = '0;
      if (ram_hit) begin
         if (!run) host_rdata = ram_rd;
      end else if (reg_hit) begin
         unique case (idx)
            REG_START: if (!run) host_rdata[RAM_AW-1:0] = ptr;
            REG_STATE: host_rdata[0] = run;
            REG_DONE:  host_rdata[0] = done_flag;
            REG_IEN:   host_rdata[0] = ien;
            REG_XDIS:  host_rdata[0] = xdis;
            REG_NMIS:  host_rdata[NMIS_W-1:0] = nmis;
            default:   host_rdata = '0;
         endcase
      end
   end

   assign irq_n = !(done_flag && ien);

endmodule

// File: rtl/clc_launch_chk.sv
module clc_launch_chk #(
   parameter int OP_W   = 5,
   parameter int RSV_LO = 30
) (
   input logic            clk,
   input logic            rst_n,
   input logic            run,
   input logic            done_flag,
   input logic            irq_n,
   input logic            start_wr,
   input logic            kill_wr,
   input logic            guarded,
   input logic [OP_W-1:0] fetch_op
);

   logic op_ends;
   assign op_ends = (fetch_op == OP_W'(0)) || (fetch_op == OP_W'(1)) ||
                    (int'(fetch_op) >= RSV_LO);

   // R2
   start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && start_wr) |=> run);

   // R3
   op_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && op_ends) |=> !run);

   // R5
   kill_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && kill_wr) |=> !run);

   // R6
   guard_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && guarded) |=> !run);

   // R7
   keep_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !guarded && !kill_wr && !op_ends) |=> run);

   // R8
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> done_flag);

   // R9
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> done_flag);

endmodule

bind clc_launch_top clc_launch_chk #(.OP_W(OP_W), .RSV_LO(RSV_LO)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .done_flag (done_flag),
   .irq_n     (irq_n),
   .start_wr  (start_wr),
   .kill_wr   (kill_wr),
   .guarded   (guarded),
   .fetch_op  (fetch_op)
);

// File: tb/clc_launch_top_tb.sv
module clc_launch_top_tb;

   localparam int HA_W = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            host_sel = 1'b0;
   logic            host_we = 1'b0;
   logic [HA_W-1:0] host_addr = '0;
   logic [15:0]     host_wdata = '0;
   logic [15:0]     host_rdata;
   logic            irq_n;

   int checks = 0;
   int errors = 0;
   bit pend = 1'b0;
   bit finished = 1'b0;

   bit    kind_q[$];
   int    exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   clc_launch_top u_dut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .irq_n(irq_n)
   );

   function automatic logic [HA_W-1:0] rega(int i);
      return {1'b1, 3'b000, i[2:0]};
   endfunction

   function automatic logic [15:0] cmd(logic [4:0] op);
      return {op, 11'h2A5};
   endfunction

   // monitor: pops expected items and compares
   always @(negedge clk) begin
      if (pend && kind_q.size() > 0) begin
         automatic bit    k = kind_q.pop_front();
         automatic int    e = exp_q.pop_front();
         automatic string t = tag_q.pop_front();
         automatic int    a = k ? int'(irq_n) : int'(host_rdata);
         checks++;
         if (a != e) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
         end
      end
   end

   task automatic wr(logic [HA_W-1:0] a, logic [15:0] d);
      @(posedge clk); #1;
      host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
   endtask

   task automatic rd_chk(logic [HA_W-1:0] a, int e, string t);
      @(posedge clk); #1;
      host_sel = 1'b1; host_we = 1'b0; host_addr = a; host_wdata = '0;
      kind_q.push_back(1'b0); exp_q.push_back(e); tag_q.push_back(t);
      pend = 1'b1;
      @(negedge clk); #1;
      pend = 1'b0;
   endtask

   task automatic irq_chk(int e, string t);
      @(posedge clk); #1;
      host_sel = 1'b0; host_we = 1'b0;
      kind_q.push_back(1'b1); exp_q.push_back(e); tag_q.push_back(t);
      pend = 1'b1;
      @(negedge clk); #1;
      pend = 1'b0;
   endtask

   task automatic idle(int n);
      @(posedge clk); #1;
      host_sel = 1'b0; host_we = 1'b0;
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state
      rd_chk(rega(1), 0, "R11 run after reset");
      rd_chk(rega(4), 0, "R11 done after reset");
      rd_chk(rega(5), 0, "R11 enable after reset");
      rd_chk(rega(6), 0, "R11 spare after reset");
      irq_chk(1, "R11 irq_n after reset");

      // R10 idle access
      wr(7'd5, 16'hABCD);
      wr(rega(6), 16'h005A);
      wr(rega(3), 16'h0001);
      rd_chk(7'd5, 16'hABCD, "R10 memory readback");
      rd_chk(rega(6), 16'h005A, "R10 spare byte");
      rd_chk(rega(3), 1, "R10 spare bit");

      // R2 R3 halt list: no-ops 4..6, halt at 7
      for (int a = 4; a < 7; a++) wr(HA_W'(a), cmd(5'h05));
      wr(7'd7, cmd(5'h00));
      wr(rega(0), 16'd4);
      rd_chk(rega(1), 1, "R2 run cycle 1");
      rd_chk(rega(1), 1, "R1 run cycle 2");
      rd_chk(rega(1), 1, "R1 run cycle 3");
      rd_chk(rega(1), 1, "R1 run cycle 4");
      rd_chk(rega(1), 0, "R3 halt stops run");
      rd_chk(rega(0), 7, "R3 pointer at halt");
      rd_chk(rega(4), 1, "R8 done set by halt");
      irq_chk(1, "R9 masked irq stays high");
      wr(rega(5), 16'h0001);
      irq_chk(0, "R9 irq low when enabled");
      wr(rega(4), 16'h0000);
      rd_chk(rega(4), 1, "R8 write 0 keeps done");
      wr(rega(4), 16'h0001);
      rd_chk(rega(4), 0, "R8 write 1 clears done");
      irq_chk(1, "R9 irq released");

      // R3 breakpoint as first word
      wr(7'd10, cmd(5'h01));
      wr(rega(0), 16'd10);
      idle(3);
      rd_chk(rega(1), 0, "R3 breakpoint stops");
      rd_chk(rega(0), 10, "R3 pointer at breakpoint");
      wr(rega(4), 16'h0001);

      // R4 reserved 1E
      wr(7'd12, cmd(5'h1E));
      wr(rega(0), 16'd12);
      idle(3);
      rd_chk(rega(0), 12, "R4 reserved 1E stops");
      rd_chk(rega(4), 1, "R4 done after 1E");
      wr(rega(4), 16'h0001);

      // R1 R4: 1D advances, 1F stops
      wr(7'd13, cmd(5'h1D));
      wr(7'd14, cmd(5'h1F));
      wr(rega(0), 16'd13);
      idle(4);
      rd_chk(rega(0), 14, "R1 1D advances, R4 1F stops");
      wr(rega(4), 16'h0001);

      // long no-op run 20..49, halt at 50
      for (int a = 20; a < 50; a++) wr(HA_W'(a), cmd(5'h07));
      wr(7'd50, cmd(5'h00));

      // R5 stop register while running
      wr(rega(0), 16'd20);
      rd_chk(rega(1), 1, "R5 running before stop");
      rd_chk(rega(1), 1, "R5 still running");
      wr(rega(2), 16'h0000);
      rd_chk(rega(1), 0, "R5 stop write ends run");
      rd_chk(rega(0), 22, "R5 pointer held");
      rd_chk(rega(4), 1, "R8 done after stop write");
      wr(rega(4), 16'h0001);

      // R5 stop write while idle
      wr(rega(2), 16'hFFFF);
      rd_chk(rega(4), 0, "R5 idle stop write ignored");
      rd_chk(rega(1), 0, "R5 idle stays idle");

      // R6 guarded memory write while running is discarded
      wr(rega(0), 16'd20);
      rd_chk(rega(1), 1, "R6 running");
      wr(7'd30, cmd(5'h00));
      rd_chk(rega(1), 0, "R6 memory write stops run");
      rd_chk(7'd30, cmd(5'h07), "R6 memory write discarded");
      rd_chk(rega(4), 1, "R6 done set");
      wr(rega(4), 16'h0001);

      // R6 pointer read while running
      wr(rega(0), 16'd20);
      rd_chk(rega(0), 0, "R6 pointer read while running");
      rd_chk(rega(1), 0, "R6 pointer read stops run");
      rd_chk(rega(0), 20, "R6 pointer held at read");
      wr(rega(4), 16'h0001);

      // R7 allowed registers while running
      wr(rega(0), 16'd20);
      wr(rega(5), 16'h0000);
      wr(rega(3), 16'h0000);
      rd_chk(rega(6), 16'h005A, "R7 spare read while running");
      wr(rega(4), 16'h0001);
      rd_chk(rega(1), 1, "R7 still running");
      wr(rega(2), 16'h0000);
      rd_chk(rega(1), 0, "R7 stopped by stop write");
      rd_chk(rega(3), 0, "R7 spare written while running");
      irq_chk(1, "R9 irq high with enable cleared");

      idle(2);
      finished = 1'b1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

endmodule